// File: doc/BRIEF.md
# Ping-Pong Receive Buffer with Address Filter

This block is the receive half of a small Ethernet MAC. Bytes of an incoming frame arrive on an 8-bit stream qualified by a valid strobe and an end-of-frame marker. The block checks each frame's destination against a 48-bit station address. It writes accepted frames into one of two on-chip frame stores. Software uses the stores in turn. After reading a frame, it hands that store back by clearing a "full" flag in the store's control word.

Each frame is written into the selected store as its bytes arrive. Some frames are dropped: those that fail the destination check, and those that arrive while the selected store is still full. A dropped frame leaves no trace in the control words. When a frame is accepted, the store is marked full and may raise a one-cycle interrupt. If alternation is enabled, selection then moves to the other store. A 32-bit word-only register bus gives access to both stores, their control words and a global interrupt enable.

Top module: `ethrx_pingpong`

## Requirements
- R1: After reset the selected store is store 0, both control words and the global enable read 0, `rx_ready` is 1 and `irq` is 0.
- R2: The bus uses 32-bit word accesses, and address bits [1:0] are ignored. Read data appears on `bus_rdata` the cycle after the read request and is held until the next read. Store 0 data starts at 0x1000 and its control word is at 0x17FC. Store 1 data starts at 0x1800 and its control word is at 0x1FFC. The global enable is at 0x07F8. Bus writes into the data areas have no effect, and unmapped addresses read as 0.
- R3: A frame is accepted when bit 7 of its first byte is 1. It is also accepted when it has at least six bytes and byte k (k = 0..5) equals `station_addr[8k+7:8k]`. Any other frame changes no control word, raises no interrupt and does not move the selection.
- R4: Byte n of an accepted frame is stored in data word n/4 of the selected store, at bits [8(n mod 4)+7 : 8(n mod 4)].
- R5: When the last byte of an accepted frame is taken, bit 0 (full) of the selected store's control word is set.
- R6: A frame whose first byte arrives while the selected store's full bit is 1 is lost. It changes neither store's data, neither control word and not the selection, and it raises no interrupt.
- R7: With PINGPONG=1 the selection toggles after each accepted frame. With PINGPONG=0 store 0 is always used.
- R8: `irq` pulses high for one cycle, the cycle after an accepted frame's last byte, only when bit 3 of store 0's control word and bit 31 of the global enable are both 1. Bit 3 of store 1's control word has no effect.
- R9: Writing a control word stores the written value, so a write with bit 0 clear releases that store. `rx_ready` equals the inverse of the selected store's full bit.
- R10: Only the first BUF_BYTES-4 bytes (2044 by default) of a frame are stored. A longer frame is still accepted and marked full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| station_addr | input | 48 | Station address, byte k at bits [8k+7:8k] |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | `rx_data` holds a byte this cycle |
| rx_last | input | 1 | This byte ends the frame |
| rx_ready | output | 1 | Selected store is free |
| bus_en | input | 1 | Bus access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 13 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The tests use several kinds of destination:
- A matching unicast destination separates the byte-by-byte compare path from the group-bit path.
- A group destination shows that bit 7 of the first byte bypasses the compare.
- A unicast destination that differs only in its fourth byte shows that a mismatch in the middle of the header is caught.
- A four-byte matching prefix shows that a frame shorter than an address is rejected.

Frames sent while the selected store is full show that a loss is silent. A frame of more than 2044 bytes exercises the truncation edge. A second instance with alternation disabled shows that store 1 is never used.

// File: rtl/ethrx_pkg.sv
package ethrx_pkg;
    localparam int ADDR_BYTES = 6;

    typedef enum logic [1:0] {
        CAP_IDLE,
        CAP_RECV,
        CAP_SKIP
    } cap_state_e;
endpackage

// File: rtl/ethrx_capture.sv
module ethrx_capture
    import ethrx_pkg::*;
#(
    parameter int BUF_BYTES = 2048
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [8*ADDR_BYTES-1:0]           station_addr,
    input  logic [7:0]                        rx_data,
    input  logic                              rx_valid,
    input  logic                              rx_last,
    input  logic                              busy_sel,
    output logic                              wr_en,
    output logic [$clog2(BUF_BYTES/4)-1:0]    wr_word,
    output logic [1:0]                        wr_lane,
    output logic [7:0]                        wr_byte,
    output logic                              done
);
    localparam int WORD_AW    = $clog2(BUF_BYTES / 4);
    localparam int CNT_W      = $clog2(BUF_BYTES) + 1;
    localparam int DATA_BYTES = BUF_BYTES - 4;

    typedef struct packed {
        cap_state_e         st;
        logic [CNT_W-1:0]   cnt;
        logic               match;
        logic               grp;
    } cap_t;

    cap_t q, d;

    logic             first;
    logic [CNT_W-1:0] idx;
    logic [7:0]       sa_byte;
    logic             in_hdr;
    logic             grp_now;
    logic             match_now;
    logic             long_enough;
    logic             room;

    always_comb begin
        first   = (q.st == CAP_IDLE);
        idx     = first ? '0 : q.cnt;
        sa_byte = '0;
        for (int k = 0; k < ADDR_BYTES; k++) begin
            if (idx == CNT_W'(k)) sa_byte = station_addr[8*k +: 8];
        end
        in_hdr      = (idx < CNT_W'(ADDR_BYTES));
        grp_now     = first ? rx_data[7] : q.grp;
        match_now   = (first | q.match) & (~in_hdr | (rx_data == sa_byte));
        long_enough = (idx >= CNT_W'(ADDR_BYTES - 1));
        room        = (idx < CNT_W'(DATA_BYTES));

        d     = q;
        wr_en = 1'b0;
        done  = 1'b0;

        if (rx_valid) begin
            case (q.st)
                CAP_SKIP: begin
                    if (rx_last) d.st = CAP_IDLE;
                end
                default: begin
                    if (first && busy_sel) begin
                        d.st = rx_last ? CAP_IDLE : CAP_SKIP;
                    end else begin
                        wr_en   = room;
                        d.grp   = grp_now;
                        d.match = match_now;
                        d.cnt   = room ? idx + 1'b1 : idx;
                        if (rx_last) begin
                            done = grp_now | (match_now & long_enough);
                            d.st = CAP_IDLE;
                        end else begin
                            d.st = (grp_now | match_now) ? CAP_RECV : CAP_SKIP;
                        end
                    end
                end
            endcase
        end
    end

    assign wr_word = idx[WORD_AW+1:2];
    assign wr_lane = idx[1:0];
    assign wr_byte = rx_data;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st    <= CAP_IDLE;
            q.cnt   <= '0;
            q.match <= 1'b0;
            q.grp   <= 1'b0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/ethrx_store.sv
module ethrx_store #(
    parameter int BUF_BYTES = 2048
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic                            wr_bank,
    input  logic [$clog2(BUF_BYTES/4)-1:0]  wr_word,
    input  logic [1:0]                      wr_lane,
    input  logic [7:0]                      wr_byte,
    input  logic                            rd_en,
    input  logic                            rd_bank,
    input  logic [$clog2(BUF_BYTES/4)-1:0]  rd_word,
    output logic [31:0]                     rd_data
);
    localparam int DEPTH      = BUF_BYTES / 4;
    localparam int WORD_AW    = $clog2(DEPTH);
    localparam int DATA_WORDS = (BUF_BYTES - 4) / 4;

    logic [1:0][31:0] bank_rd;
    logic             rd_bank_q;

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic [31:0] mem [DEPTH];
        logic [31:0] rd_q;

        always_ff @(posedge clk) begin
            if (wr_en && (wr_bank == 1'(b))) mem[wr_word][8*wr_lane +: 8] <= wr_byte;
            if (rd_en && (rd_bank == 1'(b))) rd_q <= mem[rd_word];
        end

        assign bank_rd[b] = rd_q;
    end

    always_ff @(posedge clk) begin
        if (rd_en) rd_bank_q <= rd_bank;
    end

    assign rd_data = bank_rd[rd_bank_q];

    // R10: byte writes never reach the word that shares the control address
    p_wr_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_word < WORD_AW'(DATA_WORDS)));
endmodule

// File: rtl/ethrx_csr.sv
module ethrx_csr #(
    parameter int BUF_BYTES = 2048,
    parameter bit PINGPONG  = 1'b1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            bus_en,
    input  logic                            bus_we,
    input  logic [$clog2(BUF_BYTES)+1:0]    bus_addr,
    input  logic [31:0]                     bus_wdata,
    output logic [31:0]                     bus_rdata,
    input  logic                            done,
    input  logic [31:0]                     mem_rd_data,
    output logic                            mem_rd_en,
    output logic                            mem_rd_bank,
    output logic [$clog2(BUF_BYTES/4)-1:0]  mem_rd_word,
    output logic                            sel,
    output logic                            busy_sel,
    output logic                            irq
);
    localparam int BUF_AW  = $clog2(BUF_BYTES);
    localparam int ADDR_W  = BUF_AW + 2;
    localparam int WORD_AW = BUF_AW - 2;
    localparam logic [ADDR_W-1:0] GIE_ADDR = ADDR_W'(BUF_BYTES - 8);

    typedef struct packed {
        logic             sel;
        logic [1:0][31:0] ctrl;
        logic [31:0]      gie;
        logic             irq;
        logic [31:0]      rd_reg;
        logic             rd_mem;
    } csr_t;

    csr_t q, d;

    logic               is_rx;
    logic               bank;
    logic [WORD_AW-1:0] word;
    logic               is_ctrl;
    logic               is_gie;
    logic               rd_req;
    logic               unused_lsb;

    assign unused_lsb = ^bus_addr[1:0];

    always_comb begin
        is_rx   = bus_addr[ADDR_W-1];
        bank    = bus_addr[BUF_AW];
        word    = bus_addr[BUF_AW-1:2];
        is_ctrl = is_rx & (&word);
        is_gie  = ~is_rx & (bus_addr[ADDR_W-1:2] == GIE_ADDR[ADDR_W-1:2]);
        rd_req  = bus_en & ~bus_we;

        d     = q;
        d.irq = 1'b0;

        if (bus_en && bus_we) begin
            if (is_ctrl) d.ctrl[bank] = bus_wdata;
            if (is_gie)  d.gie        = bus_wdata;
        end

        if (done) begin
            d.ctrl[q.sel][0] = 1'b1;
            d.irq            = q.ctrl[0][3] & q.gie[31];
            if (PINGPONG) d.sel = ~q.sel;
        end

        if (rd_req) begin
            d.rd_mem = is_rx & ~is_ctrl;
            d.rd_reg = is_ctrl ? q.ctrl[bank] : (is_gie ? q.gie : 32'h0);
        end
    end

    assign mem_rd_en   = rd_req & is_rx & ~is_ctrl;
    assign mem_rd_bank = bank;
    assign mem_rd_word = word;
    assign bus_rdata   = q.rd_mem ? mem_rd_data : q.rd_reg;
    assign sel         = q.sel;
    assign busy_sel    = q.ctrl[q.sel][0];
    assign irq         = q.irq;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    p_sel_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(q.sel));

    if (PINGPONG) begin : g_flip_chk
        p_sel_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
            done |=> (q.sel != $past(q.sel)));
    end

    // R5: completed frame leaves the store it used marked full
    p_full_s0_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !q.sel) |=> q.ctrl[0][0]);
    p_full_s1_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && q.sel) |=> q.ctrl[1][0]);

    p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        q.irq |-> $past(done));
endmodule

// File: rtl/ethrx_pingpong.sv
module ethrx_pingpong #(
    parameter int BUF_BYTES = 2048,
    parameter bit PINGPONG  = 1'b1,
    localparam int ADDR_W   = $clog2(BUF_BYTES) + 2,
    localparam int WORD_AW  = $clog2(BUF_BYTES / 4)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [47:0]       station_addr,
    input  logic [7:0]        rx_data,
    input  logic              rx_valid,
    input  logic              rx_last,
    output logic              rx_ready,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);
    logic               busy_sel;
    logic               sel;
    logic               wr_en;
    logic [WORD_AW-1:0] wr_word;
    logic [1:0]         wr_lane;
    logic [7:0]         wr_byte;
    logic               done;
    logic               mem_rd_en;
    logic               mem_rd_bank;
    logic [WORD_AW-1:0] mem_rd_word;
    logic [31:0]        mem_rd_data;

    ethrx_capture #(.BUF_BYTES(BUF_BYTES)) u_capture (
        .clk          (clk),
        .rst_n        (rst_n),
        .station_addr (station_addr),
        .rx_data      (rx_data),
        .rx_valid     (rx_valid),
        .rx_last      (rx_last),
        .busy_sel     (busy_sel),
        .wr_en        (wr_en),
        .wr_word      (wr_word),
        .wr_lane      (wr_lane),
        .wr_byte      (wr_byte),
        .done         (done)
    );

    ethrx_store #(.BUF_BYTES(BUF_BYTES)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_bank (sel),
        .wr_word (wr_word),
        .wr_lane (wr_lane),
        .wr_byte (wr_byte),
        .rd_en   (mem_rd_en),
        .rd_bank (mem_rd_bank),
        .rd_word (mem_rd_word),
        .rd_data (mem_rd_data)
    );

    ethrx_csr #(.BUF_BYTES(BUF_BYTES), .PINGPONG(PINGPONG)) u_csr (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_en      (bus_en),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .done        (done),
        .mem_rd_data (mem_rd_data),
        .mem_rd_en   (mem_rd_en),
        .mem_rd_bank (mem_rd_bank),
        .mem_rd_word (mem_rd_word),
        .sel         (sel),
        .busy_sel    (busy_sel),
        .irq         (irq)
    );

    assign rx_ready = ~busy_sel;
endmodule

// File: tb/ethrx_pingpong_test.sv
module ethrx_pingpong_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [47:0] STATION = 48'h6655_4433_2211;
    localparam logic [12:0] A_GIE   = 13'h07F8;
    localparam logic [12:0] A_CTRL0 = 13'h17FC;
    localparam logic [12:0] A_CTRL1 = 13'h1FFC;
    localparam logic [12:0] A_DATA0 = 13'h1000;
    localparam logic [12:0] A_DATA1 = 13'h1800;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_valid = 1'b0;
    logic        rx_last = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [12:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        rx_ready, irq, rx_ready_fx, irq_fx;
    logic [31:0] bus_rdata, bus_rdata_fx;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0]  frm [0:2099];
    logic        irq_seen, irq_fx_seen;
    logic [31:0] rd_a, rd_b;

    always #(CLK_PERIOD/2) clk = ~clk;

    ethrx_pingpong uut (
        .clk(clk), .rst_n(rst_n), .station_addr(STATION),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_last(rx_last), .rx_ready(rx_ready),
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    ethrx_pingpong #(.PINGPONG(1'b0)) uut_fixed (
        .clk(clk), .rst_n(rst_n), .station_addr(STATION),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_last(rx_last), .rx_ready(rx_ready_fx),
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata_fx), .irq(irq_fx)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic bus_wr(logic [12:0] a, logic [31:0] v);
        @(negedge clk); bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk); bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_rd(logic [12:0] a);
        @(negedge clk); bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk); bus_en = 1'b0; rd_a = bus_rdata; rd_b = bus_rdata_fx;
    endtask

    task automatic fill(logic [47:0] dst, int seed);
        for (int i = 0; i < 2100; i++)
            frm[i] = (i < 6) ? dst[8*i +: 8] : 8'(seed + 3*i);
    endtask

    task automatic send(int len);
        for (int i = 0; i < len; i++) begin
            @(negedge clk); rx_valid = 1'b1; rx_data = frm[i]; rx_last = (i == len - 1);
        end
        @(negedge clk); rx_valid = 1'b0; rx_last = 1'b0;
        irq_seen = irq; irq_fx_seen = irq_fx;
    endtask

    function automatic logic [31:0] exp_word(int w);
        return {frm[4*w+3], frm[4*w+2], frm[4*w+1], frm[4*w]};
    endfunction

    task automatic t_reset();
        chk("R1 rx_ready", 32'(rx_ready), 32'd1);
        chk("R1 irq", 32'(irq), 32'd0);
        bus_rd(A_CTRL0); chk("R1 ctrl0", rd_a, 32'h0);
        bus_rd(A_CTRL1); chk("R1 ctrl1", rd_a, 32'h0);
        bus_rd(A_GIE);   chk("R1 gie", rd_a, 32'h0);
        bus_rd(13'h0000); chk("R2 unmapped reads zero", rd_a, 32'h0);
    endtask

    task automatic t_unicast();
        bus_wr(A_GIE, 32'h8000_0000);
        bus_wr(A_CTRL0, 32'h8);
        bus_rd(A_GIE); chk("R2 gie readback", rd_a, 32'h8000_0000);
        fill(STATION, 17);
        send(10);
        chk("R8 irq after unicast", 32'(irq_seen), 32'd1);
        @(negedge clk); chk("R8 irq one cycle", 32'(irq), 32'd0);
        bus_rd(A_CTRL0); chk("R5 ctrl0 full", rd_a, 32'h9);
        for (int w = 0; w < 2; w++) begin
            bus_rd(A_DATA0 + 13'(4*w)); chk("R4 store0 word", rd_a, exp_word(w));
        end
        chk("R7 R9 moved to free store1", 32'(rx_ready), 32'd1);
    endtask

    task automatic t_group();
        fill(48'h0000_0000_0081, 40);
        send(8);
        chk("R3 group accepted irq via ctrl0 bit3 R8", 32'(irq_seen), 32'd1);
        bus_rd(A_CTRL1); chk("R5 ctrl1 full", rd_a, 32'h1);
        bus_rd(A_DATA1);      chk("R4 store1 word0", rd_a, exp_word(0));
        bus_rd(A_DATA1 + 13'd4); chk("R4 store1 word1", rd_a, exp_word(1));
        chk("R9 back on full store0", 32'(rx_ready), 32'd0);
    endtask

    task automatic t_lost();
        logic [31:0] keep;
        bus_rd(A_DATA0); keep = rd_a;
        fill(48'h0000_0000_0083, 90);
        send(12);
        chk("R6 lost no irq", 32'(irq_seen), 32'd0);
        bus_rd(A_CTRL0); chk("R6 ctrl0 unchanged", rd_a, 32'h9);
        bus_rd(A_CTRL1); chk("R6 ctrl1 unchanged", rd_a, 32'h1);
        bus_rd(A_DATA0); chk("R6 store0 data unchanged", rd_a, keep);
        bus_wr(A_CTRL0, 32'h8);
        chk("R9 release sets rx_ready", 32'(rx_ready), 32'd1);
    endtask

    task automatic t_filter();
        fill(STATION, 5);
        frm[3] = frm[3] ^ 8'h01;
        send(12);
        chk("R3 mismatch no irq", 32'(irq_seen), 32'd0);
        bus_rd(A_CTRL0); chk("R3 mismatch ctrl0", rd_a, 32'h8);
        fill(STATION, 6);
        send(4);
        chk("R3 short frame no irq", 32'(irq_seen), 32'd0);
        bus_rd(A_CTRL0); chk("R3 short frame ctrl0", rd_a, 32'h8);
        fill(48'h0000_0000_00F0, 70);
        send(6);
        bus_rd(A_CTRL0); chk("R3 R7 selection kept store0", rd_a, 32'h9);
        bus_rd(A_DATA0); chk("R4 store0 after filter", rd_a, exp_word(0));
    endtask

    task automatic t_irq_gate();
        bus_wr(A_GIE, 32'h0);
        bus_wr(A_CTRL0, 32'h8);
        bus_wr(A_CTRL1, 32'h0);
        fill(48'h0000_0000_0080, 11);
        send(8);
        chk("R8 gie off no irq", 32'(irq_seen), 32'd0);
        bus_rd(A_CTRL1); chk("R5 ctrl1 full gie off", rd_a, 32'h1);
        bus_wr(A_GIE, 32'h8000_0000);
        bus_wr(A_CTRL0, 32'h0);
        bus_wr(A_CTRL1, 32'h8);
        fill(48'h0000_0000_0080, 23);
        send(8);
        chk("R8 ctrl1 bit3 no irq", 32'(irq_seen), 32'd0);
        bus_rd(A_CTRL0); chk("R5 ctrl0 full", rd_a, 32'h1);
    endtask

    task automatic t_ro_data();
        bus_wr(A_DATA0, 32'hDEAD_BEEF);
        bus_rd(A_DATA0); chk("R2 data write ignored", rd_a, exp_word(0));
    endtask

    task automatic t_trunc();
        bus_wr(A_CTRL0, 32'h0);
        bus_wr(A_CTRL1, 32'h0);
        fill(48'h0000_0000_00C1, 9);
        send(2050);
        bus_rd(A_CTRL1); chk("R10 long frame marked full", rd_a, 32'h1);
        bus_rd(A_DATA1 + 13'd2040); chk("R10 last stored word", rd_a, exp_word(510));
        bus_rd(A_DATA1); chk("R10 first word", rd_a, exp_word(0));
        chk("R10 R7 selection back on store0", 32'(rx_ready), 32'd1);
    endtask

    task automatic t_fixed();
        do_reset();
        bus_wr(A_GIE, 32'h8000_0000);
        bus_wr(A_CTRL0, 32'h8);
        fill(48'h0000_0000_0085, 33);
        send(8);
        chk("R7 fixed irq", 32'(irq_fx_seen), 32'd1);
        chk("R7 fixed store0 full", 32'(rx_ready_fx), 32'd0);
        bus_rd(A_CTRL1); chk("R7 fixed ctrl1 untouched", rd_b, 32'h0);
        bus_wr(A_CTRL0, 32'h8);
        fill(48'h0000_0000_0087, 61);
        send(8);
        bus_rd(A_CTRL0); chk("R7 fixed ctrl0 again", rd_b, 32'h9);
        bus_rd(A_CTRL1); chk("R7 fixed ctrl1 still clear", rd_b, 32'h0);
        bus_rd(A_DATA0); chk("R7 fixed store0 data", rd_b, exp_word(0));
    endtask

    initial begin
        repeat (200000 - 50000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        t_reset();
        t_unicast();
        t_group();
        t_lost();
        t_filter();
        t_irq_gate();
        t_ro_data();
        t_trunc();
        t_fixed();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule